// File: doc/BRIEF.md
# Keyboard, Joystick and Beeper I/O Port

This block is the port-mapped I/O unit of a small 8-bit home computer. It watches a 16-bit I/O address together with separate read and write strobes. On a read of the main port it returns the state of an eight-row keyboard matrix, five keys per row. The upper address byte chooses which rows take part, and all chosen rows are merged into one value. The same read also returns the cassette input level. On a write it stores the beeper, cassette-output and border-colour controls. A second, fixed low-byte address returns a five-bit joystick.

The block does not scan the physical matrix. It receives eight 5-bit row vectors and passes them through two flip-flop stages before use. The read path has a small state machine with two named states:
- `RD_IDLE`: waiting for a read strobe. When `io_rd` is high, the transition *capture* stores the read word, raises `io_rvalid` for one cycle and moves to `RD_HOLD`.
- `RD_HOLD`: waits for the strobe to drop. The transition *release* (`io_rd` low) returns to `RD_IDLE`. While `io_rd` stays high the machine remains in `RD_HOLD`.

Top module: `hc_io_port`

## Requirements
- R1: The main port is addressed when `io_addr[0]` is 0. A write with `io_addr[0]` = 1 leaves `spk_n`, `mic_n` and `border_rgb` unchanged.
- R2: On a main-port read, row k (k = 0..7) is selected when `io_addr[8+k]` is 0. Row k is carried in `key_rows[5k+4:5k]`. Read bits 4..0 equal 5'b11111 ANDed with every selected row, so they read 5'b11111 when no row is selected.
- R3: On a main-port read, bit 6 equals `ear_in` whatever the upper address byte holds, and bits 7 and 5 read 1.
- R4: A main-port write stores the speaker and MIC controls and the border colour:
  - `spk_n` takes data bit 4 and `mic_n` takes data bit 3.
  - `border_rgb` becomes {red, green, blue} = {data[1], data[2], data[0]}.
  - Data bits 7..5 have no effect on any output.
- R5: A read whose low address byte is 8'h1F returns {3'b000, `joy_in`}, where `joy_in` bits 4..0 are fire, up, down, left and right, active high.
- R6: A read whose address is neither the main port nor 8'h1F in the low byte returns 8'hFF.
- R7: After reset, `spk_n`, `mic_n`, `border_rgb` and `io_rvalid` are all 0.
- R8: A read strobe produces exactly one `io_rvalid` pulse, one cycle long. It is registered at the first clock edge where `io_rd` is high, and `io_rdata` holds the read word while `io_rvalid` is high. A strobe held high gives no further pulse until it has dropped.
- R9: Keyboard rows pass through two flip-flop stages. A read captured on the first edge after a row change returns the old row value. A read captured three or more edges after the change returns the new value.
- R10: A main-port write of 8'h00 drives `spk_n`, `mic_n` and every `border_rgb` bit to 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read word |
| io_rvalid | output | 1 | One-cycle read-valid pulse |
| key_rows | input | 40 | Eight 5-bit keyboard rows, active low |
| ear_in | input | 1 | Cassette input level |
| joy_in | input | 5 | Joystick lines, active high |
| spk_n | output | 1 | Speaker control, active low |
| mic_n | output | 1 | Cassette output control, active low |
| border_rgb | output | 3 | Border colour {red, green, blue} |

## Verification
The hardest case to reach from the ports is the merge of several rows at once. It only shows up when a key is pressed in one selected row and the same key position is released in another. The stimulus sweeps all 256 upper-byte values against two row patterns that differ per row and per bit position. The second case is a read landing exactly one edge after a row change. The bench reaches it by changing the rows and raising the read strobe on the same falling edge, so the capture sees the synchroniser's previous contents.

// File: rtl/hcio_pkg.sv
package hcio_pkg;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int NUM_ROWS = 8;
    localparam int ROW_BITS = 5;
    localparam int ROW_LSB  = 8;
    localparam logic [7:0] JOY_LOW = 8'h1F;
    localparam logic [7:0] IDLE_RD = 8'hFF;

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_HOLD = 1'b1
    } rd_state_t;

    typedef enum logic [1:0] {
        SRC_MAIN,
        SRC_JOY,
        SRC_NONE
    } rd_src_t;
endpackage

// File: rtl/hcio_row_sync.sv
module hcio_row_sync #(
    parameter int NUM_ROWS = 8,
    parameter int ROW_BITS = 5,
    localparam int W = NUM_ROWS * ROW_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rows_async,
    output logic [W-1:0] rows_sync
);
    for (genvar k = 0; k < NUM_ROWS; k++) begin : g_row
        logic [ROW_BITS-1:0] stage1;
        logic [ROW_BITS-1:0] stage2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1 <= '1;
                stage2 <= '1;
            end else begin
                stage1 <= rows_async[k*ROW_BITS +: ROW_BITS];
                stage2 <= stage1;
            end
        end
        assign rows_sync[k*ROW_BITS +: ROW_BITS] = stage2;
    end
endmodule

// File: rtl/hcio_key_merge.sv
module hcio_key_merge #(
    parameter int NUM_ROWS = 8,
    parameter int ROW_BITS = 5
) (
    input  logic [NUM_ROWS*ROW_BITS-1:0] rows,
    input  logic [NUM_ROWS-1:0]          sel_n,
    output logic [ROW_BITS-1:0]          merged
);
    always_comb begin
        merged = '1;
        for (int k = 0; k < NUM_ROWS; k++) begin
            if (!sel_n[k]) begin
                merged = merged & rows[k*ROW_BITS +: ROW_BITS];
            end
        end
    end
endmodule

// File: rtl/hcio_ctrl_reg.sv
module hcio_ctrl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic [7:0] wdata,
    output logic       spk_n,
    output logic       mic_n,
    output logic [2:0] border_rgb
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spk_n      <= 1'b0;
            mic_n      <= 1'b0;
            border_rgb <= 3'b000;
        end else if (wr_hit) begin
            spk_n      <= wdata[4];
            mic_n      <= wdata[3];
            border_rgb <= {wdata[1], wdata[2], wdata[0]};
        end
    end
endmodule

// File: rtl/hc_io_port.sv
module hc_io_port
    import hcio_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            io_addr,
    input  logic                         io_rd,
    input  logic                         io_wr,
    input  logic [DATA_W-1:0]            io_wdata,
    output logic [DATA_W-1:0]            io_rdata,
    output logic                         io_rvalid,
    input  logic [NUM_ROWS*ROW_BITS-1:0] key_rows,
    input  logic                         ear_in,
    input  logic [ROW_BITS-1:0]          joy_in,
    output logic                         spk_n,
    output logic                         mic_n,
    output logic [2:0]                   border_rgb
);
    localparam int JOY_PAD = DATA_W - ROW_BITS;

    logic [NUM_ROWS*ROW_BITS-1:0] rows_s;
    logic [ROW_BITS-1:0]          merged;
    logic                         main_hit;
    rd_src_t                      src;
    logic [DATA_W-1:0]            rd_word;
    rd_state_t                    state_q, state_d;
    logic                         capture;

    assign main_hit = ~io_addr[0];

    hcio_row_sync #(.NUM_ROWS(NUM_ROWS), .ROW_BITS(ROW_BITS)) u_sync (
        .clk(clk), .rst_n(rst_n), .rows_async(key_rows), .rows_sync(rows_s)
    );

    hcio_key_merge #(.NUM_ROWS(NUM_ROWS), .ROW_BITS(ROW_BITS)) u_merge (
        .rows(rows_s), .sel_n(io_addr[ROW_LSB +: NUM_ROWS]), .merged(merged)
    );

    hcio_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_hit(io_wr && main_hit),
        .wdata(io_wdata), .spk_n(spk_n), .mic_n(mic_n), .border_rgb(border_rgb)
    );

    always_comb begin
        if (main_hit)                 src = SRC_MAIN;
        else if (io_addr[7:0] == JOY_LOW) src = SRC_JOY;
        else                          src = SRC_NONE;
    end

    always_comb begin
        unique case (src)
            SRC_MAIN: rd_word = {1'b1, ear_in, 1'b1, merged};
            SRC_JOY:  rd_word = {{JOY_PAD{1'b0}}, joy_in};
            default:  rd_word = IDLE_RD;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            RD_IDLE: if (io_rd) begin
                capture = 1'b1;
                state_d = RD_HOLD;
            end
            RD_HOLD: if (!io_rd) state_d = RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_rvalid <= 1'b0;
            io_rdata  <= '0;
        end else begin
            io_rvalid <= capture;
            if (capture) io_rdata <= rd_word;
        end
    end
endmodule

// File: rtl/hc_io_port_chk.sv
module hc_io_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_addr,
    input logic        io_rd,
    input logic        io_wr,
    input logic [7:0]  io_wdata,
    input logic [7:0]  io_rdata,
    input logic        io_rvalid,
    input logic        ear_in,
    input logic [4:0]  joy_in,
    input logic        spk_n,
    input logic        mic_n,
    input logic [2:0]  border_rgb
);
    assert_wr_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr[0]) |=> ($stable(spk_n) && $stable(mic_n) && $stable(border_rgb)));

    assert_wr_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_addr[0]) |=> (spk_n == $past(io_wdata[4]) && mic_n == $past(io_wdata[3])
            && border_rgb == {$past(io_wdata[1]), $past(io_wdata[2]), $past(io_wdata[0])}));

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        io_rvalid |=> !io_rvalid);

    assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_rvalid) |-> $past(io_rd));

    assert_unmapped_ff_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rvalid && $past(io_addr[0]) && $past(io_addr[7:0]) != 8'h1F) |-> io_rdata == 8'hFF);

    assert_fixed_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rvalid && !$past(io_addr[0])) |-> (io_rdata[7] && io_rdata[5]));
endmodule

bind hc_io_port hc_io_port_chk u_chk (.*);

// File: tb/sim_hc_io_port.sv
module sim_hc_io_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'hFFFF;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        io_rvalid;
    logic [39:0] key_rows = '1;
    logic        ear_in = 1'b0;
    logic [4:0]  joy_in = 5'h00;
    logic        spk_n, mic_n;
    logic [2:0]  border_rgb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    hc_io_port u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_merge(input logic [39:0] rows, input logic [7:0] sel_n);
        logic [4:0] acc = 5'b11111;
        for (int k = 0; k < 8; k++)
            if (!sel_n[k]) acc = acc & rows[k*5 +: 5];
        return acc;
    endfunction

    task automatic do_read(input logic [15:0] a, output logic [7:0] d, output logic v);
        @(negedge clk); io_addr = a; io_rd = 1'b1;
        @(negedge clk); io_rd = 1'b0; d = io_rdata; v = io_rvalid;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] wd);
        @(negedge clk); io_addr = a; io_wdata = wd; io_wr = 1'b1;
        @(negedge clk); io_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [7:0] d;
        logic v;
        int pulses;
        logic [39:0] old_rows;

        #1;
        check("R7", {spk_n, mic_n, border_rgb, io_rvalid}, 6'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", {spk_n, mic_n, border_rgb, io_rvalid}, 6'd0);

        // R2/R3: sweep every row selection under two row patterns
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 8; k++)
                key_rows[k*5 +: 5] = (p == 0) ? ~(5'b1 << (k % 5)) : 5'((k * 7 + 3) ^ 5'h15);
            ear_in = p[0];
            settle();
            for (int s = 0; s < 256; s++) begin
                do_read({s[7:0], 8'hFE}, d, v);
                check("R8", v, 1'b1);
                check("R2", d[4:0], exp_merge(key_rows, s[7:0]));
                check("R3", {d[7], d[6], d[5]}, {1'b1, ear_in, 1'b1});
            end
        end

        // R5: joystick at low byte 1F, any upper byte
        for (int j = 0; j < 32; j++) begin
            joy_in = j[4:0];
            do_read({8'(j * 9), 8'h1F}, d, v);
            check("R5", d, {3'b000, j[4:0]});
        end

        // R6: unmapped low bytes read FF
        for (int a = 1; a < 256; a += 2) begin
            if (a != 8'h1F) begin
                do_read({8'h00, a[7:0]}, d, v);
                check("R6", d, 8'hFF);
            end
        end

        // R4: every write value
        for (int w = 0; w < 256; w++) begin
            do_write({8'(w), 8'hFE}, w[7:0]);
            check("R4", {spk_n, mic_n, border_rgb}, {w[4], w[3], w[1], w[2], w[0]});
        end

        // R1: writes with bit 0 high do nothing
        do_write(16'h00FE, 8'h1F);
        do_write(16'h00FF, 8'h00);
        check("R1", {spk_n, mic_n, border_rgb}, 5'b11111);
        do_write(16'hFFFD, 8'h00);
        check("R1", {spk_n, mic_n, border_rgb}, 5'b11111);

        // R10: zero clears everything
        do_write(16'h12FE, 8'h00);
        check("R10", {spk_n, mic_n, border_rgb}, 5'b00000);

        // R8: held strobe gives one pulse
        pulses = 0;
        @(negedge clk); io_addr = 16'h00FE; io_rd = 1'b1;
        repeat (5) begin
            @(negedge clk);
            if (io_rvalid) pulses++;
        end
        io_rd = 1'b0;
        repeat (2) begin
            @(negedge clk);
            if (io_rvalid) pulses++;
        end
        check("R8", pulses, 1);

        // R9: rows change together with the read strobe
        key_rows = '1;
        settle();
        old_rows = key_rows;
        @(negedge clk); key_rows = '0; io_addr = 16'h00FE; io_rd = 1'b1;
        @(negedge clk); io_rd = 1'b0;
        check("R9", io_rdata[4:0], exp_merge(old_rows, 8'h00));
        repeat (3) @(negedge clk);
        do_read(16'h00FE, d, v);
        check("R9", d[4:0], 5'b00000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule